// File: doc/BRIEF.md
# Handshaked Control-Register Bus Master

This block lets a host reach the narrow internal configuration bus of a PHY. The host hands over one request on a valid/ready port: an operation bit (read or write), a 16-bit register address and a 16-bit write word. The block then runs the strobe-and-acknowledge sequence on the PHY side and reports the outcome on a one-cycle done or error pulse, with read data alongside.

Every step on the PHY side is a four-phase handshake. The block raises one strobe, waits for acknowledge high, drops the strobe while holding the data-in bus, then waits for acknowledge low. Both the address and the data travel over one shared 16-bit data-in bus. A write takes three steps: address capture, data capture, then commit. A read takes two: address capture, then a read strobe with data-in cleared. Acknowledge is looked at only once every `POLL_CYC` cycles. If a wait sees no change within `TIMEOUT_CYC` cycles, the transaction is abandoned.

The request port has no queue. `req_ready` is high only while the block is idle, and a request moves only in a cycle where `req_valid` and `req_ready` are both high. A host that holds `req_valid` while the block is busy is simply stalled. The response pins carry no back-pressure, so the host must take `rsp_done`/`rsp_err` in the cycle they pulse.

Top module: `crbus_master`

## Requirements
- R1: `req_ready` is high exactly when the block is idle. It is low in the cycle after a request is accepted, and no strobe is high while it is high.
- R2: The address step puts the request address on `phy_din`, holds it there for `HOLD_CYC` (default 2) cycles with all strobes low, and only then raises `phy_cap_addr` with the same value on `phy_din`.
- R3: A strobe stays high until acknowledge is sampled high. It then falls with `phy_din` unchanged. The next strobe is not raised until acknowledge has been sampled low.
- R4: A write raises strobes in this order: `phy_cap_addr` with the address, then `phy_cap_data` with the write word, then `phy_wr_stb` with the same write word.
- R5: A read raises `phy_cap_addr` and then `phy_rd_stb`, with `phy_din` equal to 0 while `phy_rd_stb` rises. `rsp_rdata` returns the `phy_dout` value captured at the poll that sees acknowledge high.
- R6: Acknowledge is sampled every `POLL_CYC` cycles. If a wait ends without the expected acknowledge level after `TIMEOUT_CYC` cycles, the block pulses `rsp_err`, drives all strobes low and returns to idle without pulsing `rsp_done`.
- R7: At most one of the four strobes is high in any cycle.
- R8: `rsp_done` and `rsp_err` are single-cycle pulses, never high together. Each accepted request yields exactly one of them.
- R9: Addresses 0x0000 and 0xFFFF, and data words 0x0000 and 0xFFFF, pass through unchanged.
- R10: During reset all strobes are low, `phy_din` is 0, `req_ready` is high and neither response pulse is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | DW | Register address |
| req_wdata | input | DW | Write word |
| rsp_done | output | 1 | One-cycle success pulse |
| rsp_err | output | 1 | One-cycle timeout pulse |
| rsp_rdata | output | DW | Read result, valid with `rsp_done` after a read |
| phy_din | output | DW | Shared address/data bus to the PHY |
| phy_cap_addr | output | 1 | Address-capture strobe |
| phy_cap_data | output | 1 | Data-capture strobe |
| phy_wr_stb | output | 1 | Write-commit strobe |
| phy_rd_stb | output | 1 | Read strobe |
| phy_ack | input | 1 | Acknowledge from the PHY |
| phy_dout | input | DW | Read data from the PHY |

## Verification
The checker enforces several rules on every cycle. At most one strobe is high. A strobe falls only after acknowledge was high or on an abort. `phy_din` is steady across a falling strobe and across the setup before an address capture. Done and error never coincide, and the idle state shows no strobe. Other properties depend on a whole transaction, and only the bench scenarios against a responder model can show them. These are the order of strobes and the bus value at each rise, the read data, and round trips at the address extremes. They also include a timeout with acknowledge never rising, and one with acknowledge stuck high.

// File: rtl/crbus_pkg.sv
package crbus_pkg;
  // Step index; also selects which strobe is raised.
  typedef enum logic [1:0] {
    PH_ADDR   = 2'd0,
    PH_DATA   = 2'd1,
    PH_COMMIT = 2'd2,
    PH_READ   = 2'd3
  } phase_t;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_RISE  = 3'd2,
    ST_FALL  = 3'd3
  } state_t;

  localparam int unsigned NUM_STROBES = 4;
endpackage

// File: rtl/crbus_poll_timer.sv
module crbus_poll_timer #(
  parameter int unsigned POLL_CYC    = 5,
  parameter int unsigned TIMEOUT_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  output logic tick,
  output logic last
);
  localparam int unsigned MAX_POLLS = (TIMEOUT_CYC / POLL_CYC) < 1 ? 1 : (TIMEOUT_CYC / POLL_CYC);
  localparam int unsigned PW = $clog2(POLL_CYC + 1);
  localparam int unsigned NW = $clog2(MAX_POLLS + 1);

  logic [PW-1:0] pcnt;
  logic [NW-1:0] ncnt;

  assign tick = run && (pcnt == PW'(POLL_CYC - 1));
  assign last = (ncnt == NW'(MAX_POLLS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !run || clr) begin
      pcnt <= '0;
      ncnt <= '0;
    end else if (tick) begin
      pcnt <= '0;
      ncnt <= ncnt + 1'b1;
    end else begin
      pcnt <= pcnt + 1'b1;
    end
  end
endmodule

// File: rtl/crbus_strobe_dec.sv
module crbus_strobe_dec #(
  parameter int unsigned N = 4
) (
  input  logic                 en,
  input  logic [$clog2(N)-1:0] sel,
  output logic [N-1:0]         stb
);
  for (genvar gi = 0; gi < N; gi++) begin : g_stb
    assign stb[gi] = en && (sel == ($clog2(N))'(gi));
  end
endmodule

// File: rtl/crbus_seq.sv
module crbus_seq
  import crbus_pkg::*;
#(
  parameter int unsigned DW       = 16,
  parameter int unsigned HOLD_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [DW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  input  logic          phy_ack,
  input  logic [DW-1:0] phy_dout,
  input  logic          tick,
  input  logic          last,
  output logic          run,
  output logic          clr,
  output logic          strobe_en,
  output logic [1:0]    phase,
  output logic [DW-1:0] din,
  output logic          done,
  output logic          err,
  output logic [DW-1:0] rdata
);
  localparam int unsigned HW = $clog2(HOLD_CYC + 1) < 1 ? 1 : $clog2(HOLD_CYC + 1);

  state_t        st;
  phase_t        ph;
  logic          is_wr;
  logic [DW-1:0] wdata_q;
  logic [HW-1:0] hold_cnt;
  logic [HW-1:0] hold_end;
  logic          ack_ok;

  assign req_ready = (st == ST_IDLE);
  assign run       = (st == ST_RISE) || (st == ST_FALL);
  assign ack_ok    = (st == ST_RISE) ? phy_ack : !phy_ack;
  assign clr       = tick && ack_ok;
  assign strobe_en = (st == ST_RISE);
  assign phase     = ph;
  assign hold_end  = (ph == PH_ADDR || ph == PH_DATA) ? HW'(HOLD_CYC - 1) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      ph       <= PH_ADDR;
      is_wr    <= 1'b0;
      wdata_q  <= '0;
      hold_cnt <= '0;
      din      <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
      rdata    <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      unique case (st)
        ST_IDLE: if (req_valid) begin
          st       <= ST_SETUP;
          ph       <= PH_ADDR;
          is_wr    <= req_write;
          wdata_q  <= req_wdata;
          din      <= req_addr;
          hold_cnt <= '0;
        end
        ST_SETUP: begin
          if (hold_cnt == hold_end) st <= ST_RISE;
          else hold_cnt <= hold_cnt + 1'b1;
        end
        ST_RISE: if (tick) begin
          if (phy_ack) begin
            if (ph == PH_READ) rdata <= phy_dout;
            st <= ST_FALL;
          end else if (last) begin
            err <= 1'b1;
            st  <= ST_IDLE;
          end
        end
        ST_FALL: if (tick) begin
          if (!phy_ack) begin
            hold_cnt <= '0;
            unique case (ph)
              PH_ADDR: begin
                st  <= ST_SETUP;
                ph  <= is_wr ? PH_DATA : PH_READ;
                din <= is_wr ? wdata_q : '0;
              end
              PH_DATA: begin
                st <= ST_SETUP;
                ph <= PH_COMMIT;
              end
              default: begin
                done <= 1'b1;
                st   <= ST_IDLE;
              end
            endcase
          end else if (last) begin
            err <= 1'b1;
            st  <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/crbus_master.sv
module crbus_master
  import crbus_pkg::*;
#(
  parameter int unsigned DW          = 16,
  parameter int unsigned HOLD_CYC    = 2,
  parameter int unsigned POLL_CYC    = 5,
  parameter int unsigned TIMEOUT_CYC = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [DW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_done,
  output logic          rsp_err,
  output logic [DW-1:0] rsp_rdata,
  output logic [DW-1:0] phy_din,
  output logic          phy_cap_addr,
  output logic          phy_cap_data,
  output logic          phy_wr_stb,
  output logic          phy_rd_stb,
  input  logic          phy_ack,
  input  logic [DW-1:0] phy_dout
);
  logic                   tick, last, run, clr, strobe_en;
  logic [1:0]             phase;
  logic [NUM_STROBES-1:0] stb;

  crbus_seq #(.DW(DW), .HOLD_CYC(HOLD_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .phy_ack(phy_ack), .phy_dout(phy_dout),
    .tick(tick), .last(last), .run(run), .clr(clr),
    .strobe_en(strobe_en), .phase(phase), .din(phy_din),
    .done(rsp_done), .err(rsp_err), .rdata(rsp_rdata)
  );

  crbus_poll_timer #(.POLL_CYC(POLL_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .clr(clr), .tick(tick), .last(last)
  );

  crbus_strobe_dec #(.N(NUM_STROBES)) u_dec (
    .en(strobe_en), .sel(phase), .stb(stb)
  );

  assign phy_cap_addr = stb[PH_ADDR];
  assign phy_cap_data = stb[PH_DATA];
  assign phy_wr_stb   = stb[PH_COMMIT];
  assign phy_rd_stb   = stb[PH_READ];
endmodule

// File: rtl/crbus_master_chk.sv
module crbus_master_chk #(
  parameter int unsigned DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_done,
  input logic          rsp_err,
  input logic [DW-1:0] phy_din,
  input logic          phy_cap_addr,
  input logic          phy_cap_data,
  input logic          phy_wr_stb,
  input logic          phy_rd_stb,
  input logic          phy_ack
);
  logic any_stb;
  assign any_stb = phy_cap_addr | phy_cap_data | phy_wr_stb | phy_rd_stb;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({phy_cap_addr, phy_cap_data, phy_wr_stb, phy_rd_stb})); // R7

  AST_RSP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_done && rsp_err)); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done); // R8

  AST_IDLE_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !any_stb); // R1

  AST_DROP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(any_stb) |-> ($past(phy_ack) || rsp_err)); // R3

  AST_DIN_HELD_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(any_stb) && !rsp_err) |-> $stable(phy_din)); // R3

  AST_ADDR_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phy_cap_addr) |-> (phy_din == $past(phy_din) && phy_din == $past(phy_din, 2))); // R2

  AST_ABORT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> !any_stb); // R6
endmodule

bind crbus_master crbus_master_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
  .rsp_done(rsp_done), .rsp_err(rsp_err), .phy_din(phy_din),
  .phy_cap_addr(phy_cap_addr), .phy_cap_data(phy_cap_data),
  .phy_wr_stb(phy_wr_stb), .phy_rd_stb(phy_rd_stb), .phy_ack(phy_ack)
);

// File: tb/crbus_master_tb.sv
`timescale 1ns/1ps
module crbus_master_tb;
  localparam int DW = 16, HOLD = 2, POLL = 3, TMO = 60;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_ready, req_write = 0;
  logic [DW-1:0] req_addr = 0, req_wdata = 0;
  logic rsp_done, rsp_err;
  logic [DW-1:0] rsp_rdata, phy_din;
  logic phy_cap_addr, phy_cap_data, phy_wr_stb, phy_rd_stb;
  logic phy_ack;
  logic [DW-1:0] phy_dout;

  int checks = 0, errors = 0;
  always #5 clk = ~clk;

  crbus_master #(.DW(DW), .HOLD_CYC(HOLD), .POLL_CYC(POLL), .TIMEOUT_CYC(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .phy_din(phy_din), .phy_cap_addr(phy_cap_addr), .phy_cap_data(phy_cap_data),
    .phy_wr_stb(phy_wr_stb), .phy_rd_stb(phy_rd_stb), .phy_ack(phy_ack),
    .phy_dout(phy_dout)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] dflt(input logic [DW-1:0] a);
    return a ^ 16'hA5C3;
  endfunction

  // ---------------- responder model ----------------
  bit dead = 0, stuck = 0;
  logic [DW-1:0] mem [logic [DW-1:0]];
  logic [DW-1:0] r_addr, r_data;
  int dly;
  logic rsp_ack;
  logic any;
  assign any = phy_cap_addr | phy_cap_data | phy_wr_stb | phy_rd_stb;
  assign phy_ack = rsp_ack;

  always @(posedge clk) begin
    if (!rst_n) begin
      rsp_ack <= 0; dly <= 0; phy_dout <= '0; r_addr <= '0; r_data <= '0;
    end else if (stuck) rsp_ack <= 1;
    else if (dead) rsp_ack <= 0;
    else if (any && !rsp_ack) begin
      if (dly == 0) begin
        rsp_ack <= 1;
        dly <= int'($urandom % 8);
        if (phy_cap_addr) r_addr <= phy_din;
        if (phy_cap_data) r_data <= phy_din;
        if (phy_wr_stb) mem[r_addr] = r_data;
        if (phy_rd_stb) phy_dout <= mem.exists(r_addr) ? mem[r_addr] : dflt(r_addr);
      end else dly <= dly - 1;
    end else if (!any && rsp_ack) begin
      if (dly == 0) begin rsp_ack <= 0; dly <= int'($urandom % 8); end
      else dly <= dly - 1;
    end
  end

  // ---------------- bus sampler ----------------
  logic [DW-1:0] exp_addr, exp_wdata, d1, d2;
  logic [3:0] prev_stb;
  logic [15:0] seq_log;
  initial begin prev_stb = 0; seq_log = 0; d1 = 0; d2 = 0; exp_addr = 0; exp_wdata = 0; end

  always @(negedge clk) if (rst_n) begin
    if (phy_cap_addr && !prev_stb[0]) begin
      chk(phy_din == exp_addr, "R2 addr on din", phy_din, exp_addr);
      chk(d1 == phy_din && d2 == phy_din, "R2 addr setup hold", d2, phy_din);
      seq_log = {seq_log[11:0], 4'h1};
    end
    if (phy_cap_data && !prev_stb[1]) begin
      chk(phy_din == exp_wdata, "R4 data capture value", phy_din, exp_wdata);
      seq_log = {seq_log[11:0], 4'h2};
    end
    if (phy_wr_stb && !prev_stb[2]) begin
      chk(phy_din == exp_wdata, "R4 commit value", phy_din, exp_wdata);
      seq_log = {seq_log[11:0], 4'h3};
    end
    if (phy_rd_stb && !prev_stb[3]) begin
      chk(phy_din == 0, "R5 din zero on read", phy_din, 0);
      seq_log = {seq_log[11:0], 4'h4};
    end
    if (any && prev_stb == 0 && !stuck)
      chk(!phy_ack, "R3 strobe rises with ack low", phy_ack, 0);
    chk($countones({phy_cap_addr, phy_cap_data, phy_wr_stb, phy_rd_stb}) <= 1,
        "R7 one strobe", $countones({phy_cap_addr, phy_cap_data, phy_wr_stb, phy_rd_stb}), 1);
    prev_stb = {phy_rd_stb, phy_wr_stb, phy_cap_data, phy_cap_addr};
    d2 = d1; d1 = phy_din;
  end

  // ---------------- host side ----------------
  logic [DW-1:0] shadow [logic [DW-1:0]];

  task automatic txn(input bit wr, input logic [DW-1:0] a, input logic [DW-1:0] d,
                     output bit got_done, output bit got_err, output logic [DW-1:0] rd,
                     output int cyc);
    @(negedge clk);
    exp_addr = a; exp_wdata = d;
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0; req_addr = $urandom; req_wdata = $urandom;
    chk(!req_ready, "R1 ready low when busy", req_ready, 0);
    cyc = 1;
    while (!rsp_done && !rsp_err) begin @(negedge clk); cyc++; end
    got_done = rsp_done; got_err = rsp_err; rd = rsp_rdata;
    chk(req_ready, "R1 ready back at response", req_ready, 1);
    @(negedge clk);
    chk(!rsp_done && !rsp_err, "R8 single-cycle response", {rsp_done, rsp_err}, 0);
  endtask

  task automatic do_write(input logic [DW-1:0] a, input logic [DW-1:0] d, input string tag);
    bit dn, er; logic [DW-1:0] rd; int cyc;
    txn(1, a, d, dn, er, rd, cyc);
    chk(dn && !er, {tag, " write done"}, {dn, er}, 2);
    chk(seq_log[11:0] == 12'h123, "R4 write strobe order", seq_log[11:0], 12'h123);
    shadow[a] = d;
  endtask

  task automatic do_read(input logic [DW-1:0] a, input string tag);
    bit dn, er; logic [DW-1:0] rd, ex; int cyc;
    txn(0, a, 0, dn, er, rd, cyc);
    ex = shadow.exists(a) ? shadow[a] : dflt(a);
    chk(dn && !er, {tag, " read done"}, {dn, er}, 2);
    chk(seq_log[7:0] == 8'h14, "R5 read strobe order", seq_log[7:0], 8'h14);
    chk(rd == ex, {tag, " read data"}, rd, ex);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit dn, er; logic [DW-1:0] rd; int cyc;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!any && phy_din == 0, "R10 reset strobes/din", {any, phy_din}, 0);
    chk(req_ready && !rsp_done && !rsp_err, "R10 reset ready/resp", {req_ready, rsp_done, rsp_err}, 4);
    rst_n = 1;
    @(negedge clk);

    // directed: address and data extremes
    do_write(16'h0000, 16'hFFFF, "R9");
    do_write(16'hFFFF, 16'h0000, "R9");
    do_read(16'h0000, "R9");
    do_read(16'hFFFF, "R9");
    do_read(16'h1234, "R5");

    // random mix on a small address pool
    for (int i = 0; i < 40; i++) begin
      logic [DW-1:0] a;
      a = {12'h3A0, 4'($urandom % 16)};
      if ($urandom % 2) do_write(a, 16'($urandom), "R4");
      else do_read(a, "R5");
    end

    // timeout: acknowledge never rises
    dead = 1;
    txn(1, 16'h0042, 16'h5555, dn, er, rd, cyc);
    chk(er && !dn, "R6 no-ack timeout error", {dn, er}, 1);
    chk(cyc >= TMO && cyc <= TMO + HOLD + 4, "R6 timeout latency", cyc, TMO);
    chk(!any, "R6 strobes low after abort", any, 0);
    dead = 0;
    repeat (10) @(negedge clk);

    // timeout: acknowledge stuck high, falling wait expires
    stuck = 1;
    repeat (2) @(negedge clk);
    txn(0, 16'h0077, 0, dn, er, rd, cyc);
    chk(er && !dn, "R6 stuck-ack timeout error", {dn, er}, 1);
    chk(!any && req_ready, "R6 idle after abort", {any, req_ready}, 1);
    stuck = 0;
    repeat (20) @(negedge clk);

    // recovery after aborts
    do_write(16'hBEEF, 16'hCAFE, "R8");
    do_read(16'hBEEF, "R8");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule